// File: doc/BRIEF.md
# Accumulator Field Extractor with Position Pointer

This unit keeps four 64-bit accumulators, each made of a HI and a LO half, along with a 6-bit position pointer and an extract-fail flag. Software-visible operations arrive one per cycle on a command port. Each command carries a sub-opcode, a 2-bit accumulator index, a 6-bit immediate amount and a 32-bit register operand.

The field extract operations pull a bit field out of the selected accumulator. The field's most significant bit sits at the pointer. One variant also moves the pointer down past the field it has consumed, which lets a program read a packed bitstream field by field. The move operation feeds the stream: the old LO moves up into HI, a fresh 32-bit word goes into LO, and the pointer rises by 32. The shift operation moves the whole 64-bit accumulator left or right by a signed amount.

Extract results are registered and appear one cycle after the command. The pointer, the flag and the accumulators also update on that same clock edge.

Top module: `acc_field_unit`

## Requirements
- R1: After reset the pointer is 0, the fail flag is 0, every accumulator is zero, res_data_o is 0 and res_valid_o is 0.
- R2: Sub-opcode 0x02 is extract, 0x0A is extract-and-decrement, 0x1A is shift and 0x1F is move. The codes 0x03, 0x0B and 0x1B do the same as 0x02, 0x0A and 0x1A, except that the amount comes from reg_val_i[5:0] instead of imm_amt_i.
- R3: An extract with size s, where pos >= s, returns bits [pos : pos-s] of {HI,LO}, right-aligned and zero-extended to 32 bits. It clears the fail flag. res_valid_o is high for exactly the cycle after the command.
- R4: An extract with pos < s sets the fail flag and returns zero. The pointer does not change.
- R5: A successful extract-and-decrement writes (pos - s - 1) mod 64 to the pointer, so pos == s gives 63. Plain extract never changes the pointer.
- R6: Move copies the old LO into HI and reg_val_i into LO. When the pointer is at most 32, 32 is added to it modulo 64, so 32 becomes 0. When the pointer is above 32 it stays unchanged.
- R7: Shift reads its amount as a 6-bit two's-complement number. A positive amount is a logical right shift of {HI,LO}. A negative amount is a left shift by the magnitude, so -32 moves LO into HI and zeroes LO. Zero leaves the accumulator unchanged. The new HI and LO are the upper and lower 32 bits of the result.
- R8: acc_sel_i chooses the accumulator. Only that accumulator can change. acc_hi_o and acc_lo_o show it combinationally.
- R9: A command with an unlisted sub-opcode, or any cycle with op_valid_i low, changes no accumulator, no pointer and no flag.
- R10: The extract size is the amount modulo 32, so amount bit 5 has no effect on extracts, and the field is size+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Command present this cycle |
| op_code_i | input | 5 | Sub-opcode |
| acc_sel_i | input | 2 | Accumulator index |
| imm_amt_i | input | 6 | Immediate size or shift amount |
| reg_val_i | input | 32 | Register operand |
| acc_hi_o | output | 32 | HI half of the selected accumulator |
| acc_lo_o | output | 32 | LO half of the selected accumulator |
| res_data_o | output | 32 | Extracted field |
| res_valid_o | output | 1 | Extract result valid |
| pos_o | output | 6 | Position pointer |
| ext_fail_o | output | 1 | Extract-fail flag |

## Verification
The assertions check the following on every cycle:
- a failed extract always reports zero data;
- a plain extract leaves the pointer alone;
- idle or undecoded cycles disturb neither the pointer nor the flag;
- a move puts the previous LO into HI;
- a zero-amount shift keeps the accumulator.

Only the directed scenarios can show the following:
- the exact field values at various pointer and size pairs;
- the pointer wrap at 32+32 and at pos == size;
- the size wrap modulo 32;
- left and right shifts including -32;
- isolation between accumulators.

// File: rtl/acc_field_pkg.sv
package acc_field_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_EXT,
      K_EXTDP,
      K_SHIFT,
      K_MOVE
   } op_kind_e;

   localparam logic [4:0] C_EXT      = 5'h02;
   localparam logic [4:0] C_EXT_R    = 5'h03;
   localparam logic [4:0] C_EXTDP    = 5'h0A;
   localparam logic [4:0] C_EXTDP_R  = 5'h0B;
   localparam logic [4:0] C_SHIFT    = 5'h1A;
   localparam logic [4:0] C_SHIFT_R  = 5'h1B;
   localparam logic [4:0] C_MOVE     = 5'h1F;

   function automatic op_kind_e decode_kind(input logic [4:0] c);
      case (c)
         C_EXT, C_EXT_R:     return K_EXT;
         C_EXTDP, C_EXTDP_R: return K_EXTDP;
         C_SHIFT, C_SHIFT_R: return K_SHIFT;
         C_MOVE:             return K_MOVE;
         default:            return K_NONE;
      endcase
   endfunction

   function automatic logic amount_from_reg(input logic [4:0] c);
      return (c == C_EXT_R) || (c == C_EXTDP_R) || (c == C_SHIFT_R);
   endfunction

endpackage

// File: rtl/acc_bank.sv
module acc_bank #(
   parameter int HALF_W  = 32,
   parameter int NUM_ACC = 4,
   localparam int IDX_W  = $clog2(NUM_ACC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [HALF_W-1:0] wr_hi,
   input  logic [HALF_W-1:0] wr_lo,
   output logic [HALF_W-1:0] rd_hi,
   output logic [HALF_W-1:0] rd_lo
);
   logic [HALF_W-1:0] hi_q [NUM_ACC];
   logic [HALF_W-1:0] lo_q [NUM_ACC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ACC; i++) begin
            hi_q[i] <= '0;
            lo_q[i] <= '0;
         end
      end else if (wr_en) begin
         hi_q[idx] <= wr_hi;
         lo_q[idx] <= wr_lo;
      end
   end

   assign rd_hi = hi_q[idx];
   assign rd_lo = lo_q[idx];
endmodule

// File: rtl/field_extract.sv
module field_extract #(
   parameter int HALF_W = 32,
   parameter int POS_W  = 6,
   localparam int ACC_W  = 2 * HALF_W,
   localparam int SIZE_W = $clog2(HALF_W)
) (
   input  logic [ACC_W-1:0]  acc,
   input  logic [POS_W-1:0]  pos,
   input  logic [SIZE_W-1:0] size,
   output logic              ok,
   output logic [HALF_W-1:0] field,
   output logic [POS_W-1:0]  next_pos
);
   localparam logic [SIZE_W-1:0] TOP_BIT = SIZE_W'(HALF_W - 1);

   logic [POS_W-1:0]  size_ext;
   logic [POS_W-1:0]  rsh;
   logic [ACC_W-1:0]  shifted;
   logic [HALF_W-1:0] mask;

   assign size_ext = {{(POS_W-SIZE_W){1'b0}}, size};
   assign ok       = pos >= size_ext;
   assign rsh      = pos - size_ext;
   assign shifted  = acc >> rsh;
   assign mask     = {HALF_W{1'b1}} >> (TOP_BIT - size);
   assign field    = ok ? (shifted[HALF_W-1:0] & mask) : '0;
   assign next_pos = pos - size_ext - POS_W'(1);
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
   parameter int ACC_W = 64,
   parameter int AMT_W = 6
) (
   input  logic [ACC_W-1:0] acc_in,
   input  logic [AMT_W-1:0] amt,
   output logic [ACC_W-1:0] acc_out
);
   logic             go_left;
   logic [AMT_W-1:0] mag;
   logic [ACC_W-1:0] stg [AMT_W+1];

   assign go_left = amt[AMT_W-1];
   assign mag     = go_left ? (~amt + AMT_W'(1)) : amt;
   assign stg[0]  = acc_in;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      assign stg[k+1] = !mag[k] ? stg[k] :
                        (go_left ? (stg[k] << (1 << k)) : (stg[k] >> (1 << k)));
   end

   assign acc_out = stg[AMT_W];
endmodule

// File: rtl/acc_field_unit.sv
module acc_field_unit
   import acc_field_pkg::*;
#(
   parameter int HALF_W  = 32,
   parameter int NUM_ACC = 4,
   parameter int POS_W   = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        op_valid_i,
   input  logic [4:0]  op_code_i,
   input  logic [1:0]  acc_sel_i,
   input  logic [5:0]  imm_amt_i,
   input  logic [31:0] reg_val_i,
   output logic [31:0] acc_hi_o,
   output logic [31:0] acc_lo_o,
   output logic [31:0] res_data_o,
   output logic        res_valid_o,
   output logic [5:0]  pos_o,
   output logic        ext_fail_o
);
   localparam int ACC_W  = 2 * HALF_W;
   localparam int SIZE_W = $clog2(HALF_W);
   localparam int AMT_W  = $clog2(ACC_W);
   localparam logic [POS_W-1:0] STEP = POS_W'(HALF_W);

   if (HALF_W != 32 || NUM_ACC != 4) begin : g_bad_port
      $error("port widths assume 32-bit halves and four accumulators");
   end
   if (POS_W != AMT_W) begin : g_bad_pos
      $error("pointer width must address every accumulator bit");
   end

   op_kind_e          kind;
   logic              fire;
   logic [AMT_W-1:0]  amount;
   logic [HALF_W-1:0] cur_hi, cur_lo;
   logic [ACC_W-1:0]  cur_acc, shl_acc;
   logic              ex_ok;
   logic [HALF_W-1:0] ex_field;
   logic [POS_W-1:0]  ex_next;
   logic              wr_en;
   logic [HALF_W-1:0] wr_hi, wr_lo;
   logic [POS_W-1:0]  pos_q;
   logic              fail_q;
   logic [HALF_W-1:0] res_q;
   logic              res_vld_q;

   assign kind    = decode_kind(op_code_i);
   assign fire    = op_valid_i && (kind != K_NONE);
   assign amount  = amount_from_reg(op_code_i) ? reg_val_i[AMT_W-1:0] : imm_amt_i;
   assign cur_acc = {cur_hi, cur_lo};

   acc_bank #(.HALF_W(HALF_W), .NUM_ACC(NUM_ACC)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .idx   (acc_sel_i),
      .wr_hi (wr_hi),
      .wr_lo (wr_lo),
      .rd_hi (cur_hi),
      .rd_lo (cur_lo)
   );

   field_extract #(.HALF_W(HALF_W), .POS_W(POS_W)) u_extract (
      .acc      (cur_acc),
      .pos      (pos_q),
      .size     (amount[SIZE_W-1:0]),
      .ok       (ex_ok),
      .field    (ex_field),
      .next_pos (ex_next)
   );

   acc_shifter #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_shift (
      .acc_in  (cur_acc),
      .amt     (amount),
      .acc_out (shl_acc)
   );

   always_comb begin
      wr_en = 1'b0;
      wr_hi = cur_hi;
      wr_lo = cur_lo;
      if (op_valid_i && kind == K_SHIFT) begin
         wr_en = 1'b1;
         wr_hi = shl_acc[ACC_W-1:HALF_W];
         wr_lo = shl_acc[HALF_W-1:0];
      end else if (op_valid_i && kind == K_MOVE) begin
         wr_en = 1'b1;
         wr_hi = cur_lo;
         wr_lo = reg_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         fail_q    <= 1'b0;
         res_q     <= '0;
         res_vld_q <= 1'b0;
      end else begin
         res_vld_q <= fire && (kind == K_EXT || kind == K_EXTDP);
         if (fire && (kind == K_EXT || kind == K_EXTDP)) begin
            res_q  <= ex_field;
            fail_q <= !ex_ok;
            if (kind == K_EXTDP && ex_ok) pos_q <= ex_next;
         end else if (fire && kind == K_MOVE && pos_q <= STEP) begin
            pos_q <= pos_q + STEP;
         end
      end
   end

   assign acc_hi_o    = cur_hi;
   assign acc_lo_o    = cur_lo;
   assign res_data_o  = res_q;
   assign res_valid_o = res_vld_q;
   assign pos_o       = pos_q;
   assign ext_fail_o  = fail_q;

   // R4: a failed extract never delivers data
   p_fail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && ext_fail_o) |-> (res_data_o == '0));

   // R5: plain extract keeps the pointer
   p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && kind == K_EXT) |=> $stable(pos_o));

   // R6: move lifts the old LO into HI
   p_move_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && kind == K_MOVE) |=>
         (acc_sel_i != $past(acc_sel_i)) || (acc_hi_o == $past(acc_lo_o)));

   // R7: zero shift keeps the accumulator
   p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && kind == K_SHIFT && amount == '0) |=>
         (acc_sel_i != $past(acc_sel_i)) || ($stable(acc_hi_o) && $stable(acc_lo_o)));

   // R9: idle or undecoded cycles leave pointer and flag alone
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire) |=> ($stable(pos_o) && $stable(ext_fail_o)));
endmodule

// File: tb/acc_field_unit_bench.sv
module acc_field_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [4:0]  op_code_i = '0;
   logic [1:0]  acc_sel_i = '0;
   logic [5:0]  imm_amt_i = '0;
   logic [31:0] reg_val_i = '0;
   logic [31:0] acc_hi_o, acc_lo_o, res_data_o;
   logic        res_valid_o, ext_fail_o;
   logic [5:0]  pos_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [63:0] m_acc [4];
   logic [5:0]  m_pos;
   logic        m_fail;
   logic [31:0] m_res;

   always #10 clk = ~clk;

   acc_field_unit u_acc_field_unit (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
      .acc_sel_i(acc_sel_i), .imm_amt_i(imm_amt_i), .reg_val_i(reg_val_i),
      .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .res_data_o(res_data_o),
      .res_valid_o(res_valid_o), .pos_o(pos_o), .ext_fail_o(ext_fail_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic look(input string tag, input logic [1:0] sel, input logic ext);
      acc_sel_i = sel;
      #1;
      chk({tag, " acc"}, {acc_hi_o, acc_lo_o}, m_acc[sel]);
      chk({tag, " pos"}, 64'(pos_o), 64'(m_pos));
      chk({tag, " flag"}, 64'(ext_fail_o), 64'(m_fail));
      chk({tag, " valid"}, 64'(res_valid_o), 64'(ext));
      if (ext) chk({tag, " data"}, 64'(res_data_o), 64'(m_res));
   endtask

   task automatic apply_op(input string tag, input logic [4:0] code, input logic [1:0] sel,
                           input logic [5:0] imm, input logic [31:0] rv, input logic vld);
      logic [5:0] amt;
      logic [4:0] sz;
      logic       ext;
      int         sa;
      amt = (code == 5'h03 || code == 5'h0B || code == 5'h1B) ? rv[5:0] : imm;
      sz  = amt[4:0];
      ext = 1'b0;
      if (vld) begin
         case (code)
            5'h02, 5'h03, 5'h0A, 5'h0B: begin
               ext = 1'b1;
               if (m_pos >= 6'(sz)) begin
                  m_res  = 32'((m_acc[sel] >> (m_pos - 6'(sz))) & ((64'h1 << (sz + 1)) - 64'h1));
                  m_fail = 1'b0;
                  if (code[3]) m_pos = m_pos - 6'(sz) - 6'd1;
               end else begin
                  m_res  = '0;
                  m_fail = 1'b1;
               end
            end
            5'h1A, 5'h1B: begin
               sa = $signed(amt);
               if (sa > 0) m_acc[sel] = m_acc[sel] >> sa;
               else if (sa < 0) m_acc[sel] = m_acc[sel] << (-sa);
            end
            5'h1F: begin
               m_acc[sel] = {m_acc[sel][31:0], rv};
               if (m_pos <= 6'd32) m_pos = m_pos + 6'd32;
            end
            default: ;
         endcase
      end
      @(negedge clk);
      op_valid_i = vld; op_code_i = code; acc_sel_i = sel; imm_amt_i = imm; reg_val_i = rv;
      @(posedge clk);
      @(negedge clk);
      op_valid_i = 1'b0;
      look(tag, sel, ext);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) m_acc[i] = '0;
      m_pos = '0; m_fail = 1'b0; m_res = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) look("R1 reset", 2'(i), 1'b0);
      chk("R1 reset data", 64'(res_data_o), 64'h0);
   endtask

   task automatic t_move;
      apply_op("R6 move pos0", 5'h1F, 2'd0, 6'd0, 32'h1234_5678, 1'b1);
      apply_op("R6 move wrap32", 5'h1F, 2'd0, 6'd0, 32'hCAFE_F00D, 1'b1);
      chk("R6 wrap to 0", 64'(pos_o), 64'h0);
      apply_op("R6 move again", 5'h1F, 2'd0, 6'd0, 32'h0F0F_0F0F, 1'b1);
      chk("R6 pos 32", 64'(pos_o), 64'd32);
   endtask

   task automatic t_extract;
      apply_op("R3 ext s7", 5'h02, 2'd0, 6'd7, 32'h0, 1'b1);
      apply_op("R5 extdp s7", 5'h0A, 2'd0, 6'd7, 32'h0, 1'b1);
      chk("R5 pos 24", 64'(pos_o), 64'd24);
      apply_op("R4 ext fail", 5'h02, 2'd0, 6'd31, 32'h0, 1'b1);
      chk("R4 flag set", 64'(ext_fail_o), 64'h1);
      apply_op("R2 ext reg size", 5'h03, 2'd0, 6'd31, 32'd5, 1'b1);
      apply_op("R10 size mod32", 5'h02, 2'd0, 6'h27, 32'h0, 1'b1);
      apply_op("R4 extdp fail", 5'h0A, 2'd0, 6'd30, 32'h0, 1'b1);
      apply_op("R5 extdp to 63", 5'h0B, 2'd0, 6'd0, 32'd24, 1'b1);
      chk("R5 pos 63", 64'(pos_o), 64'd63);
   endtask

   task automatic t_select;
      apply_op("R6 move pos>32", 5'h1F, 2'd1, 6'd0, 32'hA5A5_0001, 1'b1);
      chk("R6 pos kept", 64'(pos_o), 64'd63);
      look("R8 acc0 untouched", 2'd0, 1'b0);
      apply_op("R8 ext acc1 hi", 5'h02, 2'd1, 6'd31, 32'h0, 1'b1);
      apply_op("R3 ext acc1 low", 5'h0A, 2'd1, 6'd31, 32'h0, 1'b1);
      apply_op("R3 ext acc1 last", 5'h02, 2'd1, 6'd31, 32'h0, 1'b1);
   endtask

   task automatic t_shift;
      apply_op("R7 right 4", 5'h1A, 2'd0, 6'd4, 32'h0, 1'b1);
      apply_op("R7 left 8", 5'h1A, 2'd0, 6'h38, 32'h0, 1'b1);
      apply_op("R7 zero", 5'h1A, 2'd0, 6'd0, 32'h0, 1'b1);
      apply_op("R2 reg left1", 5'h1B, 2'd0, 6'd5, 32'h0000_003F, 1'b1);
      apply_op("R7 right 31", 5'h1A, 2'd2, 6'd31, 32'h0, 1'b1);
      apply_op("R7 left 32", 5'h1A, 2'd0, 6'h20, 32'h0, 1'b1);
      chk("R7 lo zero", 64'(acc_lo_o), 64'h0);
   endtask

   task automatic t_ignore;
      apply_op("R9 bad code", 5'h05, 2'd0, 6'd7, 32'hFFFF_FFFF, 1'b1);
      apply_op("R9 not valid", 5'h1F, 2'd0, 6'd0, 32'hDEAD_BEEF, 1'b0);
      apply_op("R9 not valid ext", 5'h0A, 2'd0, 6'd0, 32'h0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_move();
      t_extract();
      t_select();
      t_shift();
      t_ignore();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule